// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, every clock cycle, which one of several hardware threads may use the shared instruction fetch slot. Each thread has its own program counter and a counter of its instructions that are still in the pipeline. Fetching into a thread raises that thread's counter by one. Retiring an instruction lowers it by one. A flush empties it.

In its default policy, the selector gives the slot to the eligible thread with the fewest instructions in flight. A thread that clogs the machine therefore waits until it drains. A mode input switches the selector to plain round-robin. A thread is excluded from selection if any of the following holds: it is disabled, it is stalled, it is being flushed or redirected, its counter is full, or it is asleep. A spinning thread can be put to sleep on a watched address, and it wakes when a store to that address is seen.

The outputs are a one-hot grant, the granted thread number, a fetch-valid flag and the granted thread's current program counter. Program counters move forward by a fixed fetch size on each grant, or load a new value on a redirect.

Top module: `smt_fetch_sel`

## Requirements
- R1: After reset, every in-flight count is 0, no thread is asleep, and thread t's PC is BOOT_PC + t*PC_STRIDE (0x1000 + t*0x1000 by default). The round-robin pointer starts so that thread 0 is the first one considered.
- R2: Thread t is eligible in a cycle only if all of these hold in that cycle: thread_en[t] is high, stall[t] is low, flush[t] is low, redirect[t] is low, thread t is not asleep, and its count is below the maximum (2^CNTW-1). Only an eligible thread can be granted.
- R3: With mode_rr low, the grant goes to the eligible thread with the lowest in-flight count. Ties go to the first tied thread in circular order starting after the last granted thread.
- R4: With mode_rr high, the grant goes to the first eligible thread in circular order starting after the last granted thread, whatever the counts are.
- R5: When no thread is eligible, fetch_grant is 0, fetch_vld is low, fetch_tid is 0 and fetch_pc is 0.
- R6: fetch_pc is the granted thread's current PC, within the same cycle. A grant advances that thread's PC by FETCH_BYTES (16) at the next clock edge.
- R7: redirect[t] loads redirect_pc[t*32 +: 32] into thread t's PC at the next clock edge. This takes priority over the increment.
- R8: A thread's count changes at each clock edge as follows:
  - a grant adds 1;
  - retire[t] subtracts 1, but is ignored when the count is 0;
  - a grant and a retire in the same cycle leave the count unchanged;
  - flush[t] sets the count to 0.
  The counts appear on inflight[t*4 +: 4].
- R9: A count at its maximum makes the thread ineligible, so the count never wraps. The thread becomes eligible again once a retire lowers the count.
- R10: sleep_req[t] puts thread t to sleep from the next cycle and stores sleep_addr as its watch address. A sleeping thread is never granted.
- R11: A store (store_vld) whose store_addr equals a sleeping thread's watch address wakes that thread at the next clock edge. A store with a different address has no effect. A store in the same cycle as that thread's sleep_req does not wake it.
- R12: fetch_grant has at most one bit set, and fetch_tid is the index of that bit whenever fetch_vld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rr | input | 1 | 1 selects round-robin, 0 selects fewest-in-flight |
| thread_en | input | NT | Thread enabled (has a valid context) |
| stall | input | NT | Thread cannot fetch this cycle |
| flush | input | NT | Clear the thread's in-flight count |
| retire | input | NT | One instruction of the thread retires |
| redirect | input | NT | Load a new PC for the thread |
| redirect_pc | input | NT*PCW | New PC per thread, thread t at bits t*PCW upward |
| sleep_req | input | NT | Put the thread to sleep on sleep_addr |
| sleep_addr | input | AW | Address to watch for the sleeping thread |
| store_vld | input | 1 | A store is observed this cycle |
| store_addr | input | AW | Address of the observed store |
| fetch_vld | output | 1 | A thread was granted this cycle |
| fetch_grant | output | NT | One-hot grant |
| fetch_tid | output | $clog2(NT) | Index of the granted thread |
| fetch_pc | output | PCW | PC of the granted thread |
| inflight | output | NT*CNTW | In-flight count per thread, thread t at bits t*CNTW upward |

## Verification
The grant, the thread number and fetch_pc follow from the current inputs and the registered state within the same cycle. The counts, PCs, sleep flags and the round-robin pointer change only at the next rising edge. The bench drives its inputs at the falling edge and samples all outputs one nanosecond later. At that point it compares against a model whose state reflects every earlier edge, and only then does it advance the model by one edge. An effect that is due one cycle after its cause is therefore always seen in the next sampled cycle, never the same one: a redirected PC, a bumped count, a thread that has gone to sleep or woken up.

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel #(
  parameter int NT = 4,
  parameter int PCW = 32,
  parameter int AW = 32,
  parameter int CNTW = 4,
  parameter int FETCH_BYTES = 16,
  parameter logic [PCW-1:0] BOOT_PC = 'h1000,
  parameter logic [PCW-1:0] PC_STRIDE = 'h1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_rr,
  input  logic [NT-1:0]         thread_en,
  input  logic [NT-1:0]         stall,
  input  logic [NT-1:0]         flush,
  input  logic [NT-1:0]         retire,
  input  logic [NT-1:0]         redirect,
  input  logic [NT*PCW-1:0]     redirect_pc,
  input  logic [NT-1:0]         sleep_req,
  input  logic [AW-1:0]         sleep_addr,
  input  logic                  store_vld,
  input  logic [AW-1:0]         store_addr,
  output logic                  fetch_vld,
  output logic [NT-1:0]         fetch_grant,
  output logic [$clog2(NT)-1:0] fetch_tid,
  output logic [PCW-1:0]        fetch_pc,
  output logic [NT*CNTW-1:0]    inflight
);
  localparam int TW = $clog2(NT);
  localparam logic [CNTW-1:0] CMAX = '1;

  logic [PCW-1:0]  pc_q    [NT];
  logic [CNTW-1:0] cnt_q   [NT];
  logic [AW-1:0]   watch_q [NT];
  logic [NT-1:0]   asleep_q;
  logic [TW-1:0]   last_q;
  logic [NT-1:0]   elig;
  logic [TW-1:0]   sel;
  logic            found;

  always_comb begin
    for (int t = 0; t < NT; t++)
      elig[t] = thread_en[t] & ~stall[t] & ~flush[t] & ~redirect[t] &
                ~asleep_q[t] & (cnt_q[t] != CMAX);
  end

  always_comb begin
    logic [TW-1:0]   idx;
    logic [CNTW-1:0] best;
    found = 1'b0;
    sel   = '0;
    best  = '1;
    idx   = '0;
    for (int k = 1; k <= NT; k++) begin
      idx = TW'((int'(last_q) + k) % NT);
      if (elig[idx] && (!found || (!mode_rr && cnt_q[idx] < best))) begin
        found = 1'b1;
        sel   = idx;
        best  = cnt_q[idx];
      end
    end
  end

  assign fetch_vld   = found;
  assign fetch_tid   = found ? sel : '0;
  assign fetch_grant = found ? (NT'(1) << sel) : '0;
  assign fetch_pc    = found ? pc_q[sel] : '0;

  for (genvar g = 0; g < NT; g++) begin : g_out
    assign inflight[g*CNTW +: CNTW] = cnt_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= TW'(NT - 1);
      asleep_q <= '0;
      for (int t = 0; t < NT; t++) begin
        pc_q[t]    <= BOOT_PC + PCW'(t) * PC_STRIDE;
        cnt_q[t]   <= '0;
        watch_q[t] <= '0;
      end
    end else begin
      if (found) last_q <= sel;
      for (int t = 0; t < NT; t++) begin
        if (redirect[t])
          pc_q[t] <= redirect_pc[t*PCW +: PCW];
        else if (fetch_grant[t])
          pc_q[t] <= pc_q[t] + PCW'(FETCH_BYTES);

        if (flush[t])
          cnt_q[t] <= '0;
        else
          cnt_q[t] <= cnt_q[t] + CNTW'(fetch_grant[t])
                      - CNTW'(retire[t] && cnt_q[t] != '0);

        if (sleep_req[t]) begin
          asleep_q[t] <= 1'b1;
          watch_q[t]  <= sleep_addr;
        end else if (store_vld && asleep_q[t] && watch_q[t] == store_addr) begin
          asleep_q[t] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/smt_fetch_sel_chk.sv
module smt_fetch_sel_chk #(
  parameter int NT = 4,
  parameter int PCW = 32,
  parameter int CNTW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NT-1:0]         thread_en,
  input logic [NT-1:0]         stall,
  input logic [NT-1:0]         flush,
  input logic [NT-1:0]         retire,
  input logic [NT-1:0]         redirect,
  input logic [NT*PCW-1:0]     redirect_pc,
  input logic [NT-1:0]         sleep_req,
  input logic                  fetch_vld,
  input logic [NT-1:0]         fetch_grant,
  input logic [$clog2(NT)-1:0] fetch_tid,
  input logic [PCW-1:0]        fetch_pc,
  input logic [NT*CNTW-1:0]    inflight
);
  p_grant_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_grant));
  p_tid_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> fetch_grant[fetch_tid]);
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |-> (fetch_grant == '0 && fetch_pc == '0));
  p_grant_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_grant & ~(thread_en & ~stall & ~flush & ~redirect)) == '0);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    p_redirect_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_grant[t] && $past(redirect[t])) |->
        fetch_pc == $past(redirect_pc[t*PCW +: PCW]));
    p_cnt_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_grant[t] && !retire[t] && !flush[t]) |=>
        inflight[t*CNTW +: CNTW] == CNTW'($past(inflight[t*CNTW +: CNTW]) + 1'b1));
    p_flush_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush[t] |=> inflight[t*CNTW +: CNTW] == '0);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_grant[t] |-> inflight[t*CNTW +: CNTW] != '1);
    p_sleep_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req[t] |=> !fetch_grant[t]);
  end
endmodule

bind smt_fetch_sel smt_fetch_sel_chk #(.NT(NT), .PCW(PCW), .CNTW(CNTW)) u_chk (.*);

// File: tb/tb_smt_fetch_sel.sv
module tb_smt_fetch_sel;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_rr = 1'b0;
  logic [3:0] thread_en = '0, stall = '0, flush = '0, retire = '0, redirect = '0, sleep_req = '0;
  logic [127:0] redirect_pc = '0;
  logic [31:0] sleep_addr = '0, store_addr = '0;
  logic store_vld = 1'b0;
  logic fetch_vld;
  logic [3:0] fetch_grant;
  logic [1:0] fetch_tid;
  logic [31:0] fetch_pc;
  logic [15:0] inflight;

  smt_fetch_sel dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] m_pc [NT];
  logic [3:0]  m_cnt [NT];
  logic [31:0] m_watch [NT];
  logic [3:0]  m_sleep;
  int          m_last;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [3:0] el, input logic rr, input int last);
    int s = -1;
    for (int k = 1; k <= NT; k++) begin
      int i = (last + k) % NT;
      if (el[i] && (s < 0 || (!rr && m_cnt[i] < m_cnt[s]))) s = i;
    end
    return s;
  endfunction

  task automatic cyc(string tag);
    logic [3:0] el;
    int s;
    string rq;
    #1;
    for (int t = 0; t < NT; t++)
      el[t] = thread_en[t] & ~stall[t] & ~flush[t] & ~redirect[t] & ~m_sleep[t] & (m_cnt[t] != 4'hF);
    s = pick(el, mode_rr, m_last);
    rq = (tag != "") ? tag : (s < 0) ? "R5" : mode_rr ? "R4" : "R3";
    chk(rq, "fetch_vld", 64'(fetch_vld), 64'(s >= 0));
    chk(rq, "fetch_grant", 64'(fetch_grant), (s >= 0) ? 64'(1 << s) : 64'd0);
    chk("R12", "fetch_tid", 64'(fetch_tid), (s >= 0) ? 64'(s) : 64'd0);
    chk("R6", "fetch_pc", 64'(fetch_pc), (s >= 0) ? 64'(m_pc[s]) : 64'd0);
    for (int t = 0; t < NT; t++)
      chk((tag != "") ? tag : "R8", "inflight", 64'(inflight[t*4 +: 4]), 64'(m_cnt[t]));
    for (int t = 0; t < NT; t++) begin
      logic g = (s == t);
      if (redirect[t]) m_pc[t] = redirect_pc[t*32 +: 32];
      else if (g) m_pc[t] = m_pc[t] + 32'd16;
      if (flush[t]) m_cnt[t] = 4'd0;
      else m_cnt[t] = m_cnt[t] + 4'(g) - 4'(retire[t] && m_cnt[t] != 0);
      if (sleep_req[t]) begin m_sleep[t] = 1'b1; m_watch[t] = sleep_addr; end
      else if (store_vld && m_sleep[t] && m_watch[t] == store_addr) m_sleep[t] = 1'b0;
    end
    if (s >= 0) m_last = s;
    @(negedge clk);
  endtask

  task automatic idle_in();
    stall = '0; flush = '0; retire = '0; redirect = '0; sleep_req = '0; store_vld = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int t = 0; t < NT; t++) begin
      m_pc[t] = 32'h1000 + 32'(t) * 32'h1000; m_cnt[t] = 0; m_watch[t] = 0;
    end
    m_sleep = '0; m_last = NT - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R5 nothing eligible
    cyc("R1");
    thread_en = 4'hF;
    cyc("R1");
    cyc("R3");
    cyc("R3");
    // R9 saturation on thread 1
    flush = 4'hF; cyc("R8"); flush = '0;
    thread_en = 4'b0010;
    repeat (17) cyc("R9");
    retire = 4'b0010; cyc("R9"); retire = '0;
    cyc("R9");
    cyc("R9");
    // R8 retire at zero ignored, grant+retire balanced
    flush = 4'hF; cyc("R8"); flush = '0;
    thread_en = 4'b0001; retire = 4'b0001;
    repeat (3) cyc("R8");
    retire = '0;
    // R10/R11 sleep and wake
    thread_en = 4'b1100;
    sleep_req = 4'b0100; sleep_addr = 32'h80; cyc("R10"); sleep_req = '0;
    cyc("R10");
    store_vld = 1'b1; store_addr = 32'h40; cyc("R11");
    sleep_req = 4'b1000; sleep_addr = 32'h80; store_addr = 32'h80; cyc("R11");
    sleep_req = '0; store_vld = 1'b0;
    cyc("R11");
    cyc("R11");
    store_vld = 1'b1; store_addr = 32'h80; cyc("R11"); store_vld = 1'b0;
    cyc("R11");
    // R7 redirect
    thread_en = 4'hF;
    redirect = 4'b0001; redirect_pc[31:0] = 32'hABC0; cyc("R7"); redirect = '0;
    cyc("R7"); cyc("R7"); cyc("R7");
    // R4 round-robin ignores counts
    mode_rr = 1'b1;
    repeat (6) cyc("R4");
    mode_rr = 1'b0;
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) mode_rr = ~mode_rr;
      for (int t = 0; t < NT; t++) begin
        thread_en[t] = ($urandom % 8) != 0;
        stall[t]     = ($urandom % 4) == 0;
        flush[t]     = ($urandom % 40) == 0;
        retire[t]    = ($urandom % 3) != 0;
        redirect[t]  = ($urandom % 30) == 0;
        sleep_req[t] = ($urandom % 60) == 0;
        redirect_pc[t*32 +: 32] = $urandom & 32'hFFFF_FFF0;
      end
      sleep_addr = 32'h40 * (1 + $urandom % 4);
      store_addr = 32'h40 * (1 + $urandom % 4);
      store_vld  = ($urandom % 4) == 0;
      cyc("");
    end
    idle_in();
    cyc("");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule